// File: doc/BRIEF.md
# Four-Bit Multi-Function ALU

This block is a purely combinational arithmetic and logic unit. It takes two
operands of `W` bits (4 by default), a three-bit operation code and a carry
input. It returns a result of `2*W` bits and a carry/borrow output.

Six operations are defined:

- addition and subtraction, which share one ripple-carry chain of full-adder cells;
- a logical right shift of the first operand;
- a full-width product;
- a bitwise XNOR;
- an equality test.

Every result narrower than the result bus is padded with zeros, so no result bit is ever left undriven or unknown. The two unused codes return all zeros.

The arithmetic is built from gates only. The sum and difference come out of full-adder cells. The product comes from an array of AND partial products that are summed by rows of the same ripple adder. A one-hot decode of the operation code gates each candidate result onto the bus through an AND-OR tree. The block has no clock and no state. The result is valid one propagation delay after any input changes.

Top module: `mf_alu`

## Requirements
- R1: Code 000 gives result = (A + B + carry_in) mod 16 in bits 3..0, and carry_out = bit 4 of that sum.
- R2: Code 001 gives result = (A - B) mod 16 in bits 3..0. It is formed as A + ~B + 1, and carry_in has no effect.
- R3: For code 001, carry_out is a borrow flag: 1 exactly when A < B as unsigned numbers.
- R4: Code 010 gives result = A shifted right by one place, with zero fill into bit 3. B and carry_in have no effect.
- R5: Code 011 gives result = A * B as an unsigned 8-bit product.
- R6: Code 100 gives result bits 3..0 = bitwise XNOR of A and B.
- R7: Code 101 gives result = 1 when A equals B and result = 0 otherwise.
- R8: Codes 110 and 111 give result = 0 and carry_out = 0.
- R9: carry_out is 0 for every code other than 000 and 001.
- R10: For every code except 011, result bits 7..4 are 0.
- R11: With all inputs at known 0/1 values, no bit of result or carry_out is X or Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | W | First operand (A) |
| opb | input | W | Second operand (B) |
| carry_in | input | 1 | Carry into the adder for code 000; ignored otherwise |
| op_sel | input | 3 | Operation code |
| result | output | 2*W | Zero-extended operation result |
| carry_out | output | 1 | Carry (code 000) or borrow (code 001); 0 otherwise |

## Verification
The bench sweeps every operand pair, both carry inputs and all eight codes against a behavioural model. It also repeats the extreme cases by name:

- **Addition overflow (15+15+1):** an adder with a broken carry chain or a dropped carry input shows a wrong low nibble or a missing carry.
- **Subtraction underflow (0-1):** a design that let carry_in leak into subtraction, or that reported the raw carry instead of a borrow, inverts the flag or shifts the difference by one.
- **Maximum product (15*15):** a multiplier that drops a partial-product row, or mis-wires a carry between rows, shows up in the top nibble.
- **Padding and idle codes:** a mux that leaves the upper bits undriven, or routes an adder carry into them, fails the padding check. So does one that does not zero the two idle codes.

// File: rtl/mf_alu_pkg.sv
`timescale 1ns/1ps
package mf_alu_pkg;
  localparam int SEL_W = 3;
  localparam int N_OPS = 1 << SEL_W;

  typedef enum logic [SEL_W-1:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_SHR  = 3'b010,
    OP_MUL  = 3'b011,
    OP_XNR  = 3'b100,
    OP_EQU  = 3'b101,
    OP_IDL6 = 3'b110,
    OP_IDL7 = 3'b111
  } alu_op_e;
endpackage

// File: rtl/alu_fa_cell.sv
`timescale 1ns/1ps
module alu_fa_cell (
  input  logic x,
  input  logic y,
  input  logic ci,
  output logic s,
  output logic co
);
  assign s  = x ^ y ^ ci;
  assign co = (x & y) | (x & ci) | (y & ci);
endmodule

// File: rtl/alu_ripple.sv
`timescale 1ns/1ps
module alu_ripple #(
  parameter int W = 4
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         ci,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] c;
  assign c[0] = ci;

  for (genvar i = 0; i < W; i++) begin : g_cell
    alu_fa_cell u_fa (
      .x (x[i]),
      .y (y[i]),
      .ci(c[i]),
      .s (s[i]),
      .co(c[i+1])
    );
  end

  assign co = c[W];

  logic [W:0] ref_sum;
  always_comb begin
    ref_sum = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    if (!$isunknown({x, y, ci})) begin
      // R1
      ripple_sum_chk: assert ({co, s} == ref_sum)
        else $error("ripple chain sum mismatch");
    end
  end
endmodule

// File: rtl/alu_addsub.sv
`timescale 1ns/1ps
module alu_addsub #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] res,
  output logic         cy_bw
);
  logic [W-1:0] b_eff;
  logic         ci_eff;
  logic         raw_co;

  assign b_eff  = b ^ {W{sub}};
  assign ci_eff = sub | cin;

  alu_ripple #(.W(W)) u_chain (
    .x (a),
    .y (b_eff),
    .ci(ci_eff),
    .s (res),
    .co(raw_co)
  );

  // In subtract mode a missing carry means a borrow.
  assign cy_bw = raw_co ^ sub;

  logic [W-1:0] ref_diff;
  always_comb begin
    ref_diff = a - b;
    if (!$isunknown({a, b, cin, sub}) && sub) begin
      // R2
      sub_diff_chk: assert (res == ref_diff)
        else $error("difference mismatch");
      // R3
      sub_borrow_chk: assert (cy_bw == (a < b))
        else $error("borrow flag mismatch");
    end
  end
endmodule

// File: rtl/alu_array_mul.sv
`timescale 1ns/1ps
module alu_array_mul #(
  parameter int W = 4
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] prod
);
  localparam int PW = 2 * W;

  logic [W-1:0] pp  [W];
  logic [W:0]   acc [W];

  for (genvar i = 0; i < W; i++) begin : g_pp
    assign pp[i] = a & {W{b[i]}};
  end

  assign acc[0]  = {1'b0, pp[0]};
  assign prod[0] = acc[0][0];

  for (genvar i = 1; i < W; i++) begin : g_row
    logic [W-1:0] row_s;
    logic         row_c;
    alu_ripple #(.W(W)) u_row (
      .x (acc[i-1][W:1]),
      .y (pp[i]),
      .ci(1'b0),
      .s (row_s),
      .co(row_c)
    );
    assign acc[i]  = {row_c, row_s};
    assign prod[i] = acc[i][0];
  end

  assign prod[PW-1:W] = acc[W-1][W:1];

  logic [PW-1:0] ref_prod;
  always_comb begin
    ref_prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    if (!$isunknown({a, b})) begin
      // R5
      mul_prod_chk: assert (prod == ref_prod)
        else $error("product mismatch");
    end
  end
endmodule

// File: rtl/alu_logic_unit.sv
`timescale 1ns/1ps
module alu_logic_unit #(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] shr,
  output logic [W-1:0] xnr,
  output logic         same
);
  assign shr  = {1'b0, a[W-1:1]};
  assign xnr  = ~(a ^ b);
  assign same = &xnr;

  always_comb begin
    if (!$isunknown({a, b})) begin
      // R7
      eq_flag_chk: assert (same == (a == b))
        else $error("equality flag mismatch");
      // R4
      shr_msb_chk: assert (shr[W-1] == 1'b0)
        else $error("shift fill not zero");
    end
  end
endmodule

// File: rtl/mf_alu.sv
`timescale 1ns/1ps
module mf_alu
  import mf_alu_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0]     opa,
  input  logic [W-1:0]     opb,
  input  logic             carry_in,
  input  logic [SEL_W-1:0] op_sel,
  output logic [2*W-1:0]   result,
  output logic             carry_out
);
  localparam int RW = 2 * W;

  logic [W-1:0]  as_res;
  logic          as_cb;
  logic [RW-1:0] mul_res;
  logic [W-1:0]  shr_res;
  logic [W-1:0]  xnr_res;
  logic          eq_res;

  alu_addsub #(.W(W)) u_addsub (
    .a    (opa),
    .b    (opb),
    .cin  (carry_in),
    .sub  (op_sel[0]),
    .res  (as_res),
    .cy_bw(as_cb)
  );

  alu_array_mul #(.W(W)) u_mul (
    .a   (opa),
    .b   (opb),
    .prod(mul_res)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .a   (opa),
    .b   (opb),
    .shr (shr_res),
    .xnr (xnr_res),
    .same(eq_res)
  );

  logic [N_OPS-1:0] hot;
  logic [RW-1:0]    cand  [N_OPS];
  logic [RW-1:0]    chain [N_OPS+1];

  assign cand[OP_ADD]  = {{(RW-W){1'b0}}, as_res};
  assign cand[OP_SUB]  = {{(RW-W){1'b0}}, as_res};
  assign cand[OP_SHR]  = {{(RW-W){1'b0}}, shr_res};
  assign cand[OP_MUL]  = mul_res;
  assign cand[OP_XNR]  = {{(RW-W){1'b0}}, xnr_res};
  assign cand[OP_EQU]  = {{(RW-1){1'b0}}, eq_res};
  assign cand[OP_IDL6] = '0;
  assign cand[OP_IDL7] = '0;

  assign chain[0] = '0;
  for (genvar k = 0; k < N_OPS; k++) begin : g_sel
    assign hot[k]     = (op_sel == SEL_W'(k));
    assign chain[k+1] = chain[k] | (cand[k] & {RW{hot[k]}});
  end

  assign result    = chain[N_OPS];
  assign carry_out = as_cb & (hot[OP_ADD] | hot[OP_SUB]);

  always_comb begin
    if (!$isunknown({opa, opb, carry_in, op_sel})) begin
      // R9
      cout_idle_chk: assert (op_sel[2:1] == 2'b00 || carry_out == 1'b0)
        else $error("carry_out set outside add/sub");
      // R10
      upper_zero_chk: assert (op_sel == OP_MUL || result[RW-1:W] == '0)
        else $error("upper result bits not zero");
      // R11
      known_out_chk: assert (!$isunknown({result, carry_out}))
        else $error("unknown output bit");
      // R1
      add_cout_chk: assert (op_sel != OP_ADD ||
                            carry_out == (({1'b0, opa} + {1'b0, opb} + {{W{1'b0}}, carry_in}) > (W+1)'((1 << W) - 1)))
        else $error("add carry mismatch");
    end
  end
endmodule

// File: tb/mf_alu_bench.sv
`timescale 1ns/1ps
module mf_alu_bench;
  localparam int W = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0]   a = '0;
  logic [W-1:0]   b = '0;
  logic           cin = 1'b0;
  logic [2:0]     sel = '0;
  logic [2*W-1:0] result;
  logic           cout;

  mf_alu #(.W(W)) u_mf_alu (
    .opa      (a),
    .opb      (b),
    .carry_in (cin),
    .op_sel   (sel),
    .result   (result),
    .carry_out(cout)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d a=%0d b=%0d cin=%0d got=%0d exp=%0d",
               tag, sel, a, b, cin, got, exp);
    end
  endtask

  // Behavioural model: returns {carry, result}.
  function automatic int model(input int s, input int x, input int y, input int c);
    int r, co;
    r = 0; co = 0;
    case (s)
      0: begin r = (x + y + c) % 16; co = (x + y + c) / 16; end
      1: begin r = (x - y + 16) % 16; co = (x < y) ? 1 : 0; end
      2: r = x / 2;
      3: r = x * y;
      4: r = 15 - (x ^ y);
      5: r = (x == y) ? 1 : 0;
      default: r = 0;
    endcase
    return co * 256 + r;
  endfunction

  function automatic string res_tag(input int s);
    case (s)
      0: return "R1";
      1: return "R2";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic apply(input int s, input int x, input int y, input int c);
    int e;
    @(posedge clk);
    #1;
    sel = 3'(s); a = W'(x); b = W'(y); cin = c[0];
    @(negedge clk);
    e = model(s, x, y, c);
    chk(res_tag(s), int'(result), e % 256);
    if (s == 0)      chk("R1 carry", int'(cout), e / 256);
    else if (s == 1) chk("R3 borrow", int'(cout), e / 256);
    else             chk("R9 carry idle", int'(cout), 0);
    if (s != 3)      chk("R10 upper", int'(result[7:4]), 0);
    chk("R11 known", int'($isunknown({result, cout})), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (4) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset result", int'(result), 0);
    chk("R1 reset carry", int'(cout), 0);
    // Named corners
    apply(0, 15, 15, 1);  // R1 overflow: 31 -> 15, carry 1
    apply(1, 0, 1, 0);    // R3 underflow: 15, borrow 1
    apply(1, 5, 5, 1);    // R2 carry_in ignored: 0, borrow 0
    apply(3, 15, 15, 0);  // R5 maximum product 225
    apply(2, 15, 0, 1);   // R4 zero fill: 7
    apply(6, 9, 9, 1);    // R8 idle code
    apply(7, 15, 15, 1);  // R8 idle code
    // Exhaustive sweep
    for (int s = 0; s < 8; s++)
      for (int x = 0; x < 16; x++)
        for (int y = 0; y < 16; y++)
          for (int c = 0; c < 2; c++)
            apply(s, x, y, c);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired got=%0d exp=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule